// File: doc/BRIEF.md
# Two-Wire Debug Bus Transaction Monitor

This block listens, without ever driving, to a half-duplex synchronous debug bus made of one clock line and one bidirectional data line. Both lines are oversampled by a fast system clock and pass through a two-flop synchronizer. The synchronized bus clock is then scanned for rising edges, and the data line is sampled only at those edges. While the bus clock is low, a counter measures how long it stays low. A low phase longer than a set time, 20 us by default, marks a bus reset.

After a bus reset, each bus clock pulse moves a frame tracker forward one field at a time. The fields, in order, are a start pulse, a 2-bit instruction, an optional 2-bit length, an optional wait pulse, the payload and an end pulse. When the end pulse arrives, the monitor emits one record. The record is a single-cycle valid strobe carrying the frame type, the byte count and up to four assembled data bytes. A bus reset also emits a record, with its reset flag set.

The block is used as a trace or debug probe next to the bus pins. Some other logic collects the records.

Top module: `dbgbus_monitor`

## Requirements
- R1: After system reset, `recValid` is low. No bus activity produces a record until the first bus reset has been seen.
- R2: A bus reset is a bus-clock low phase lasting more than `SYS_CLK_MHZ*RESET_US` system cycles, judged at the rising edge that ends it. At that edge:
  - any frame in progress is abandoned;
  - a record is emitted with `recRst`=1 and type, length and data all zero;
  - the next bus pulse is taken as a start field.
- R3: A low phase that does not exceed the threshold does not reset the bus, and the frame that contains it completes normally.
- R4: The two bits after the start pulse are the instruction, least significant bit first. The encoding is 0 = data read, 1 = data write, 2 = address read, 3 = address write. The instruction value is reported on `recType`.
- R5: A data-read frame is: start, instruction, 2-bit length (LSB first), one wait pulse, the payload bytes, end. Its record has `recLen` equal to the length field plus one (1 to 4).
- R6: A data-write frame is: start, instruction, 2-bit length, the payload bytes, one wait pulse, end. Its record has `recLen` equal to the length field plus one.
- R7: An address-read or address-write frame is: start, instruction, one 8-bit field, end. It has no length field and no wait pulse. Its record has `recLen`=1 and the field in `recData[7:0]`.
- R8: Each payload byte is received LSB first. The first byte goes to `recData[7:0]`, the second to `recData[15:8]`, and so on. Bytes beyond `recLen` read as zero.
- R9: `recValid` is high for exactly one system cycle per finished frame or bus reset. It goes high three system cycles after the rising edge of the end pulse (or of the reset pulse) reaches the `busClk` pin.
- R10: After an end pulse, the next bus pulse is a start field, so frames may follow one another with no reset between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low system reset |
| busClk | input | 1 | Bus clock line, idles high |
| busDat | input | 1 | Bus data line, observed only |
| recValid | output | 1 | One-cycle strobe: a record is present |
| recRst | output | 1 | The record reports a bus reset |
| recType | output | 2 | Frame instruction (0 data read, 1 data write, 2 address read, 3 address write) |
| recLen | output | 3 | Byte count of the frame (1 to 4), 0 for a reset record |
| recData | output | 32 | Assembled payload, first byte in bits 7:0 |

## Verification
Every record depends on a rising edge of the bus clock. Three register stages lie between the `busClk` pin and the output: two synchronizer flops, then the stage that follows edge detection and updates the record. The bench therefore notes the system-cycle count at each bus rising edge. On every cycle where `recValid` is high, its monitor checks that the record appeared exactly three cycles after the last rising edge. The monitor samples on the falling system edge, so the registered result is already stable when it is read. Records are compared in arrival order against expectations that the frame driver queued, and any record that arrives with the queue empty counts as a failure.

// File: rtl/dbgmon_pkg.sv
package dbgmon_pkg;

  typedef enum logic [1:0] {
    INS_DREAD  = 2'd0,
    INS_DWRITE = 2'd1,
    INS_AREAD  = 2'd2,
    INS_AWRITE = 2'd3
  } insKind_e;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic       clrFrame;   // start pulse: clear the data accumulator
    logic       shiftBit;   // sample the data line into the shifter
    logic       latchIns;   // second instruction bit has arrived
    logic       latchLen;   // second length bit has arrived
    logic       storeByte;  // eighth bit of a byte has arrived
    logic [1:0] byteIdx;    // lane to store the byte into
    logic       emitFrame;  // end pulse: publish the frame record
    logic       emitReset;  // long low pulse: publish a reset record
  } dpStrobe_t;

endpackage

// File: rtl/dbgmon_datapath.sv
module dbgmon_datapath
  import dbgmon_pkg::*;
#(
  parameter int RESET_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2,
  parameter int MAX_BYTES    = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busClk,
  input  logic                   busDat,
  input  dpStrobe_t              strb,
  output logic                   rise,
  output logic                   longLow,
  output logic [1:0]             pairNow,
  output logic [1:0]             insVal,
  output logic [1:0]             lenVal,
  output logic                   recValid,
  output logic                   recRst,
  output logic [1:0]             recType,
  output logic [2:0]             recLen,
  output logic [MAX_BYTES*8-1:0] recData
);

  localparam int BYTE_W = 8;
  localparam int DATA_W = MAX_BYTES * BYTE_W;
  localparam int CNT_W  = $clog2(RESET_CYCLES + 2);
  localparam logic [CNT_W-1:0] LOW_SAT = CNT_W'(RESET_CYCLES + 1);

  logic [SYNC_STAGES-1:0] ckSr, dSr;
  logic syncClk, syncDat, prevClk;
  logic [CNT_W-1:0] lowCnt;
  logic [BYTE_W-1:0] shReg, shNext;
  logic [DATA_W-1:0] dataAcc;

  // Synchronizer chains; the clock line idles high
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ckSr <= '1;
          dSr  <= '0;
        end else begin
          ckSr <= busClk;
          dSr  <= busDat;
        end
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ckSr <= '1;
          dSr  <= '0;
        end else begin
          ckSr <= {ckSr[SYNC_STAGES-2:0], busClk};
          dSr  <= {dSr[SYNC_STAGES-2:0], busDat};
        end
      end
    end
  endgenerate

  assign syncClk = ckSr[SYNC_STAGES-1];
  assign syncDat = dSr[SYNC_STAGES-1];

  // Edge detection and low-phase timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b1;
      lowCnt  <= '0;
    end else begin
      prevClk <= syncClk;
      if (syncClk)
        lowCnt <= '0;
      else if (lowCnt != LOW_SAT)
        lowCnt <= lowCnt + 1'b1;
    end
  end

  assign rise    = syncClk & ~prevClk;
  assign longLow = (lowCnt == LOW_SAT);

  // LSB-first shifter: newest bit enters at the top
  assign shNext  = {syncDat, shReg[BYTE_W-1:1]};
  assign pairNow = shNext[BYTE_W-1 -: 2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      insVal  <= '0;
      lenVal  <= '0;
      dataAcc <= '0;
    end else begin
      if (strb.shiftBit) shReg <= shNext;
      if (strb.latchIns) insVal <= pairNow;
      if (strb.latchLen) lenVal <= pairNow;
      if (strb.clrFrame)
        dataAcc <= '0;
      else if (strb.storeByte)
        dataAcc[strb.byteIdx*BYTE_W +: BYTE_W] <= shNext;
    end
  end

  // Output record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recValid <= 1'b0;
      recRst   <= 1'b0;
      recType  <= '0;
      recLen   <= '0;
      recData  <= '0;
    end else begin
      recValid <= strb.emitFrame | strb.emitReset;
      if (strb.emitReset) begin
        recRst  <= 1'b1;
        recType <= '0;
        recLen  <= '0;
        recData <= '0;
      end else if (strb.emitFrame) begin
        recRst  <= 1'b0;
        recType <= insVal;
        recLen  <= insVal[1] ? 3'd1 : ({1'b0, lenVal} + 3'd1);
        recData <= dataAcc;
      end
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);

  assert_reset_record_R2: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recRst) |-> (recLen == 3'd0 && recData == '0 && recType == 2'd0));

  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recRst) |-> (recLen >= 3'd1 && recLen <= 3'(MAX_BYTES)));

  assert_addr_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recRst && recType[1]) |-> (recLen == 3'd1));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recRst) |-> ((recData >> {recLen, 3'b000}) == '0));

endmodule

// File: rtl/dbgmon_ctrl.sv
module dbgmon_ctrl
  import dbgmon_pkg::*;
#(
  parameter int MAX_BYTES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rise,
  input  logic      longLow,
  input  logic [1:0] pairNow,
  input  logic [1:0] insVal,
  input  logic [1:0] lenVal,
  output dpStrobe_t strb
);

  localparam int BIT_W  = 3;
  localparam int IDX_W  = $clog2(MAX_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_INS, ST_LEN, ST_RWAIT,
    ST_PAY, ST_WWAIT, ST_ADDR, ST_END
  } state_e;

  state_e state, nextState;
  logic [BIT_W-1:0] bitCnt;
  logic [IDX_W-1:0] byteCnt;

  always_comb begin
    strb         = '0;
    strb.byteIdx = 2'(byteCnt);
    nextState    = state;
    if (rise) begin
      if (longLow) begin
        strb.emitReset = 1'b1;
        nextState      = ST_START;
      end else begin
        case (state)
          ST_START: begin
            strb.clrFrame = 1'b1;
            nextState     = ST_INS;
          end
          ST_INS: begin
            strb.shiftBit = 1'b1;
            if (bitCnt == 3'd1) begin
              strb.latchIns = 1'b1;
              nextState     = pairNow[1] ? ST_ADDR : ST_LEN;
            end
          end
          ST_LEN: begin
            strb.shiftBit = 1'b1;
            if (bitCnt == 3'd1) begin
              strb.latchLen = 1'b1;
              nextState = (insKind_e'(insVal) == INS_DREAD) ? ST_RWAIT : ST_PAY;
            end
          end
          ST_RWAIT: nextState = ST_PAY;
          ST_PAY: begin
            strb.shiftBit = 1'b1;
            if (bitCnt == 3'd7) begin
              strb.storeByte = 1'b1;
              if (2'(byteCnt) == lenVal)
                nextState = (insKind_e'(insVal) == INS_DWRITE) ? ST_WWAIT : ST_END;
            end
          end
          ST_WWAIT: nextState = ST_END;
          ST_ADDR: begin
            strb.shiftBit = 1'b1;
            if (bitCnt == 3'd7) begin
              strb.storeByte = 1'b1;
              nextState      = ST_END;
            end
          end
          ST_END: begin
            strb.emitFrame = 1'b1;
            nextState      = ST_START;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
    end else begin
      state <= nextState;
      if (nextState != state)
        bitCnt <= '0;
      else if (strb.shiftBit)
        bitCnt <= bitCnt + 1'b1;
      if (strb.clrFrame)
        byteCnt <= '0;
      else if (strb.storeByte)
        byteCnt <= byteCnt + 1'b1;
    end
  end

  assert_shift_on_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftBit |-> rise);

  assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rise && longLow) |=> (state == ST_START));

  assert_single_emit_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.emitFrame, strb.emitReset}));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !strb.emitFrame);

endmodule

// File: rtl/dbgbus_monitor.sv
module dbgbus_monitor
  import dbgmon_pkg::*;
#(
  parameter int SYS_CLK_MHZ = 250,
  parameter int RESET_US    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busClk,
  input  logic        busDat,
  output logic        recValid,
  output logic        recRst,
  output logic [1:0]  recType,
  output logic [2:0]  recLen,
  output logic [31:0] recData
);

  localparam int RESET_CYCLES = SYS_CLK_MHZ * RESET_US;
  localparam int MAX_BYTES    = 4;

  dpStrobe_t  strb;
  logic       rise, longLow;
  logic [1:0] pairNow, insVal, lenVal;

  dbgmon_datapath #(
    .RESET_CYCLES(RESET_CYCLES),
    .SYNC_STAGES (SYNC_STAGES),
    .MAX_BYTES   (MAX_BYTES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .busClk  (busClk),
    .busDat  (busDat),
    .strb    (strb),
    .rise    (rise),
    .longLow (longLow),
    .pairNow (pairNow),
    .insVal  (insVal),
    .lenVal  (lenVal),
    .recValid(recValid),
    .recRst  (recRst),
    .recType (recType),
    .recLen  (recLen),
    .recData (recData)
  );

  dbgmon_ctrl #(
    .MAX_BYTES(MAX_BYTES)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .rise   (rise),
    .longLow(longLow),
    .pairNow(pairNow),
    .insVal (insVal),
    .lenVal (lenVal),
    .strb   (strb)
  );

endmodule

// File: tb/tb_dbgbus_monitor.sv
`timescale 1ns/1ps
module tb_dbgbus_monitor;

  localparam int RESET_US  = 2;        // 500 system cycles at 250 MHz
  localparam int LONG_LOW  = 600;
  localparam int NEAR_LOW  = 400;
  localparam int LATENCY   = 3;

  logic clk = 1'b0;
  logic rstN, busClk, busDat;
  logic recValid, recRst;
  logic [1:0] recType;
  logic [2:0] recLen;
  logic [31:0] recData;

  always #2 clk = ~clk;

  dbgbus_monitor #(.SYS_CLK_MHZ(250), .RESET_US(RESET_US)) dut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busDat(busDat),
    .recValid(recValid), .recRst(recRst), .recType(recType),
    .recLen(recLen), .recData(recData)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int lastRise = 0;
  int lowLen = 6;
  int recSeen = 0;
  int pushed = 0;
  logic [37:0] expQ[$];
  string tagQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic pulse(input logic d, input int lowC);
    @(negedge clk);
    busDat = d;
    busClk = 1'b0;
    repeat (lowC) @(negedge clk);
    busClk = 1'b1;
    lastRise = cyc;
    repeat (6) @(negedge clk);
  endtask

  task automatic busReset(input bit expectRec);
    if (expectRec) begin
      expQ.push_back({1'b1, 2'd0, 3'd0, 32'd0});
      tagQ.push_back("R2");
      pushed++;
    end
    pulse(1'b0, LONG_LOW);
  endtask

  task automatic sendFrame(input int ins, input int nb, input logic [31:0] d,
                           input string tag, input bit expectRec);
    logic [31:0] expData;
    logic [1:0] lenF;
    int n;
    n = (ins >= 2) ? 1 : nb;
    lenF = 2'(n - 1);
    expData = '0;
    for (int b = 0; b < n; b++) expData[b*8 +: 8] = d[b*8 +: 8];
    if (expectRec) begin
      expQ.push_back({1'b0, 2'(ins), 3'(n), expData});
      tagQ.push_back(tag);
      pushed++;
    end
    pulse(1'b0, lowLen);                          // start
    pulse(ins[0], lowLen);                        // instruction, LSB first
    pulse(ins[1], lowLen);
    if (ins < 2) begin
      pulse(lenF[0], lowLen);
      pulse(lenF[1], lowLen);
    end
    if (ins == 0) pulse(1'b0, lowLen);            // read wait
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++) pulse(d[b*8+i], lowLen);
    if (ins == 1) pulse(1'b0, lowLen);            // write wait
    pulse(1'b0, lowLen);                          // end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && recValid === 1'b1) begin
      recSeen++;
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected record", {26'd0, recRst, recType, recLen, recData}, 64'd0);
      end else begin
        logic [37:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({recRst, recType, recLen, recData} == e, t, "record {rst,type,len,data}",
              {26'd0, recRst, recType, recLen, recData}, {26'd0, e});
        check(cyc - lastRise == LATENCY, "R9", "record latency in cycles",
              64'(cyc - lastRise), 64'(LATENCY));
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    busClk = 1'b1;
    busDat = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(recValid == 1'b0, "R1", "recValid after reset", 64'(recValid), 64'd0);

    // R1: a full frame before any bus reset is ignored
    sendFrame(0, 1, 32'h5A, "R1", 1'b0);
    repeat (10) @(negedge clk);
    check(recSeen == 0, "R1", "records before first bus reset", 64'(recSeen), 64'd0);

    busReset(1'b1);                                        // R2
    sendFrame(0, 1, 32'h0000_00A5, "R5", 1'b1);            // R5
    sendFrame(0, 4, 32'h1234_5678, "R5/R8", 1'b1);         // R5 R8, back to back R10
    sendFrame(1, 2, 32'hFFFF_BEEF, "R6/R8", 1'b1);         // R6 R8 upper bytes zero
    sendFrame(1, 3, 32'hAA90_8070, "R6/R10", 1'b1);        // R6 R10
    sendFrame(2, 1, 32'h0000_003C, "R4/R7", 1'b1);         // R4 R7 address read
    sendFrame(3, 1, 32'h0000_00C3, "R4/R7", 1'b1);         // R4 R7 address write

    // R3: low phases under the threshold do not reset
    lowLen = NEAR_LOW;
    sendFrame(1, 1, 32'h0000_0081, "R3", 1'b1);
    lowLen = 6;

    // R2: reset abandons a read frame in its payload
    pulse(1'b0, lowLen);            // start
    pulse(1'b0, lowLen);            // ins bit 0
    pulse(1'b0, lowLen);            // ins bit 1 -> data read
    pulse(1'b1, lowLen);            // length 1 -> two bytes
    pulse(1'b0, lowLen);
    pulse(1'b0, lowLen);            // wait
    pulse(1'b1, lowLen);            // part of a byte
    pulse(1'b1, lowLen);
    busReset(1'b1);
    sendFrame(0, 2, 32'h0000_9966, "R2/R10", 1'b1);

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R9", "records still owed", 64'(expQ.size()), 64'd0);
    check(recSeen == pushed, "R9", "record count", 64'(recSeen), 64'(pushed));
    finishRun();
  end

endmodule